// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a core's retirement stage and its data cache, under a memory model in which stores may be held back past later loads but stay in order among themselves. Retired stores enter one per cycle, in program order, and are written to memory one at a time from the oldest entry. Each entry holds one word address, one data word and a byte enable per byte; two stores are never combined, even when they target the same word.

Loads that are younger than the buffered stores look up their word address in the same cycle. If any buffered store matches, the newest such store provides the data. When that store does not cover every byte the load wants, a partial flag tells the core to wait for memory instead of using the forwarded word. An atomic read-modify-write or a store barrier raises a drain request; the block then holds its stall output high until every buffered store has been acknowledged by memory, and takes no new store while doing so. The memory side is a plain request/acknowledge port on which only the oldest entry is shown.

Top module: `store_queue`

## Requirements
- R1: After reset the buffer is empty: memReq, stall, ldHit and ldPartial are low and stReady is high.
- R2: The oldest entry is shown on memAddr, memData and memBe whenever memReq is high; it leaves on the clock edge where memAck is high, and stores reach memory in exactly the order they were accepted.
- R3: While memReq is high and memAck is low, memReq stays high and memAddr, memData and memBe keep their values into the next cycle.
- R4: No merging: every accepted store causes exactly one memory write, including several stores to the same word.
- R5: A store accepted on a clock edge is visible to loads from the next cycle; ldHit rises in the same cycle as a matching ldAddr, and ldData is the data of the youngest buffered store to that word address.
- R6: When no buffered store has the load's word address, ldHit and ldPartial are low.
- R7: ldPartial is high when ldHit is high and some bit i of ldBe is set while bit i of the youngest matching store's byte enable is clear (bit i covers data bits 8i+7 down to 8i).
- R8: With DEPTH entries held, stReady is low unless memAck is high in that cycle, in which case a store is accepted while the head leaves; the occupancy never exceeds DEPTH.
- R9: A drainReq pulse with a non-empty buffer makes stall high in that cycle and in every later cycle until the cycle after the last entry is acknowledged; stReady is low whenever stall is high.
- R10: A drainReq pulse on an empty buffer leaves stall low.
- R11: Once all stores are drained, memory holds the result of applying every accepted store in acceptance order with its byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Retired store offered |
| stReady | output | 1 | Store accepted on this edge when stValid is high |
| stAddr | input | AW | Word address of the store |
| stData | input | DW | Store data word |
| stBe | input | DW/8 | Byte enables of the store |
| ldAddr | input | AW | Word address of the younger load |
| ldBe | input | DW/8 | Bytes the load needs |
| ldHit | output | 1 | A buffered store matches the load address |
| ldPartial | output | 1 | The youngest match lacks some needed byte |
| ldData | output | DW | Data of the youngest matching store |
| drainReq | input | 1 | Pulse from an atomic or barrier asking for an empty buffer |
| stall | output | 1 | Requester must wait; buffer still draining |
| memReq | output | 1 | Head entry is waiting to be written |
| memAddr | output | AW | Word address of the head entry |
| memData | output | DW | Data of the head entry |
| memBe | output | DW/8 | Byte enables of the head entry |
| memAck | input | 1 | Memory accepts the head entry on this edge |

## Verification
Forwarding results, stall and stReady are combinational on the current state and inputs, so they are due in the same cycle as the stimulus; the bench drives at the falling edge and samples three nanoseconds later, after its memory model has settled memAck. A store becomes visible to loads and to the memory port one edge after acceptance, and an acknowledged entry disappears one edge after memAck, so the bench's reference queue is pushed and popped on those same rising edges and every check reads it between edges. Each memory write is compared against the queue head at the moment memAck is raised, which also holds the order and no-merge checks to the write cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } sqStrobe_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  input  logic          drainReq,
  input  logic          memAck,
  output logic          stReady,
  output logic          stall,
  output sqStrobe_t     strobe,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr
);

  logic [CW-1:0] count;
  logic [CW-1:0] countNext;
  logic          drainPend;
  logic          isEmpty;
  logic          isFull;
  logic          drainOn;

  function automatic logic [PW-1:0] bumpPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign isEmpty = (count == '0);
  assign isFull  = (count == CW'(DEPTH));
  assign drainOn = drainReq || drainPend;
  assign stall   = drainOn && !isEmpty;
  assign stReady = !stall && (!isFull || memAck);

  assign strobe.push = stValid && stReady;
  assign strobe.pop  = memAck && !isEmpty;

  always_comb begin
    countNext = count;
    if (strobe.push && !strobe.pop) countNext = count + 1'b1;
    else if (!strobe.push && strobe.pop) countNext = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      drainPend <= 1'b0;
    end else begin
      count     <= countNext;
      drainPend <= drainOn && !isEmpty && (countNext != '0);
      if (strobe.push) wrPtr <= bumpPtr(wrPtr);
      if (strobe.pop)  rdPtr <= bumpPtr(rdPtr);
    end
  end

  // R8: occupancy bound
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R8: a push into a full buffer only alongside a pop
  p_full_push_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && strobe.push) |-> strobe.pop);

  // R9: stall persists while more than one entry remains
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (drainOn && (count > CW'(1))) |=> stall);

endmodule

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  sqStrobe_t     strobe,
  input  logic [PW-1:0] wrPtr,
  input  logic [PW-1:0] rdPtr,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic [BW-1:0] stBe,
  input  logic [AW-1:0] ldAddr,
  input  logic [BW-1:0] ldBe,
  output logic          ldHit,
  output logic          ldPartial,
  output logic [DW-1:0] ldData,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  output logic [BW-1:0] memBe
);

  logic [AW-1:0]    eAddr [DEPTH];
  logic [DW-1:0]    eData [DEPTH];
  logic [BW-1:0]    eBe   [DEPTH];
  logic [DEPTH-1:0] eValid;
  logic [DEPTH-1:0] hitVec;
  logic [PW-1:0]    selIdx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic          vld;
    logic [AW-1:0] addrQ;
    logic [DW-1:0] dataQ;
    logic [BW-1:0] beQ;
    logic          wrHere;

    assign wrHere = strobe.push && (wrPtr == PW'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) vld <= 1'b0;
      else if (wrHere) vld <= 1'b1;
      else if (strobe.pop && (rdPtr == PW'(i))) vld <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        addrQ <= stAddr;
        dataQ <= stData;
        beQ   <= stBe;
      end
    end

    assign eAddr[i]  = addrQ;
    assign eData[i]  = dataQ;
    assign eBe[i]    = beQ;
    assign eValid[i] = vld;
    assign hitVec[i] = vld && (addrQ == ldAddr);
  end

  // walk from oldest to youngest; the last match wins
  always_comb begin
    logic [PW:0]   slot;
    logic [PW-1:0] idx;
    ldHit  = 1'b0;
    selIdx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = {1'b0, rdPtr} + (PW+1)'(k);
      if (slot >= (PW+1)'(DEPTH)) slot = slot - (PW+1)'(DEPTH);
      idx = slot[PW-1:0];
      if (hitVec[idx]) begin
        ldHit  = 1'b1;
        selIdx = idx;
      end
    end
  end

  assign ldData    = eData[selIdx];
  assign ldPartial = ldHit && ((ldBe & ~eBe[selIdx]) != '0);

  assign memReq  = eValid[rdPtr];
  assign memAddr = eAddr[rdPtr];
  assign memData = eData[rdPtr];
  assign memBe   = eBe[rdPtr];

  // R3: head is held until memory takes it
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !strobe.pop) |=> (memReq && $stable(memAddr) && $stable(memData) && $stable(memBe)));

  // R5: a forward implies the buffer holds something
  p_fwd_nonempty_r5: assert property (@(posedge clk) disable iff (!rstN)
    ldHit |-> memReq);

endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stValid,
  output logic            stReady,
  input  logic [AW-1:0]   stAddr,
  input  logic [DW-1:0]   stData,
  input  logic [DW/8-1:0] stBe,
  input  logic [AW-1:0]   ldAddr,
  input  logic [DW/8-1:0] ldBe,
  output logic            ldHit,
  output logic            ldPartial,
  output logic [DW-1:0]   ldData,
  input  logic            drainReq,
  output logic            stall,
  output logic            memReq,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memData,
  output logic [DW/8-1:0] memBe,
  input  logic            memAck
);

  localparam int PW = $clog2(DEPTH);

  sqStrobe_t     strobe;
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;

  sq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .drainReq(drainReq),
    .memAck(memAck), .stReady(stReady), .stall(stall), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

  sq_data #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .ldAddr(ldAddr), .ldBe(ldBe), .ldHit(ldHit), .ldPartial(ldPartial),
    .ldData(ldData), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memBe(memBe)
  );

endmodule

// File: tb/test_store_queue.sv
module test_store_queue;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [BW-1:0] b;
  } ent_t;

  logic clk = 0;
  logic rstN = 0;
  logic stValid = 0;
  logic stReady;
  logic [AW-1:0] stAddr = '0;
  logic [DW-1:0] stData = '0;
  logic [BW-1:0] stBe = '0;
  logic [AW-1:0] ldAddr = '0;
  logic [BW-1:0] ldBe = '0;
  logic ldHit, ldPartial;
  logic [DW-1:0] ldData;
  logic drainReq = 0;
  logic stall;
  logic memReq;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic [BW-1:0] memBe;
  logic memAck = 0;

  int checks = 0;
  int errors = 0;
  int nStores = 0;
  int nWrites = 0;
  logic ackBlock = 1;
  int ackLat = 0;
  int waitCnt = 0;
  ent_t expQ[$];
  logic [DW-1:0] refImg [64];
  logic [DW-1:0] memImg [64];

  always #4 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_queue (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .stBe(stBe), .ldAddr(ldAddr),
    .ldBe(ldBe), .ldHit(ldHit), .ldPartial(ldPartial), .ldData(ldData),
    .drainReq(drainReq), .stall(stall), .memReq(memReq), .memAddr(memAddr),
    .memData(memData), .memBe(memBe), .memAck(memAck)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void applyWord(ref logic [DW-1:0] img [64], input ent_t e);
    for (int b = 0; b < BW; b++)
      if (e.b[b]) img[e.a[5:0]][8*b +: 8] = e.d[8*b +: 8];
  endfunction

  // memory model and write monitor (R2, R3, R4)
  initial begin
    logic holdV;
    ent_t hold;
    holdV = 0;
    forever begin
      @(negedge clk);
      #1;
      memAck = rstN && memReq && !ackBlock && (waitCnt >= ackLat);
      if (holdV) begin
        check(memReq && memAddr == hold.a && memData == hold.d && memBe == hold.b,
              "R3 head held", {16'h0, memAddr, memData}, {16'h0, hold.a, hold.d});
      end
      holdV = rstN && memReq && !memAck;
      hold.a = memAddr; hold.d = memData; hold.b = memBe;
      if (memAck) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4 write with no pending store", 64'(memAddr), 64'h0);
        end else begin
          check(memAddr == expQ[0].a && memData == expQ[0].d && memBe == expQ[0].b,
                "R2 write order", {12'h0, memBe, memAddr, memData},
                {12'h0, expQ[0].b, expQ[0].a, expQ[0].d});
        end
        applyWord(memImg, '{a: memAddr, d: memData, b: memBe});
      end
      @(posedge clk);
      if (memAck) begin
        if (expQ.size() != 0) void'(expQ.pop_front());
        nWrites++;
        waitCnt = 0;
      end else if (memReq) begin
        waitCnt++;
      end
    end
  end

  task automatic doStore(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
    @(negedge clk);
    stValid = 1; stAddr = a; stData = d; stBe = b;
    forever begin
      #3;
      if (stReady) break;
      @(negedge clk);
    end
    @(posedge clk);
    expQ.push_back('{a: a, d: d, b: b});
    applyWord(refImg, '{a: a, d: d, b: b});
    nStores++;
    #1 stValid = 0;
  endtask

  task automatic checkLoad(input logic [AW-1:0] a, input logic [BW-1:0] b, input string tag);
    logic eHit, ePart;
    logic [DW-1:0] eData;
    @(negedge clk);
    ldAddr = a; ldBe = b;
    #3;
    eHit = 0; ePart = 0; eData = '0;
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].a == a) begin
        eHit = 1; eData = expQ[i].d; ePart = ((b & ~expQ[i].b) != '0);
        break;
      end
    end
    check(ldHit == eHit, {tag, " hit"}, 64'(ldHit), 64'(eHit));
    check(ldPartial == ePart, {tag, " partial"}, 64'(ldPartial), 64'(ePart));
    if (eHit) check(ldData == eData, {tag, " data"}, 64'(ldData), 64'(eData));
  endtask

  task automatic waitEmpty();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin refImg[i] = '0; memImg[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    #3;
    // R1 reset state
    check(!memReq && !stall && !ldHit && !ldPartial && stReady, "R1 reset state",
          {59'h0, memReq, stall, ldHit, ldPartial, stReady}, 64'h1);

    // forwarding with acks held off
    ackBlock = 1;
    doStore(16'd5, 32'hAAAA_0001, 4'hF);
    doStore(16'd9, 32'h1234_5678, 4'hF);
    doStore(16'd5, 32'hBBBB_0002, 4'b0011);
    checkLoad(16'd5, 4'b0011, "R5 youngest match");
    checkLoad(16'd9, 4'hF, "R5 single match");
    checkLoad(16'd5, 4'hF, "R7 partial cover");
    checkLoad(16'd12, 4'hF, "R6 no match");

    // fill up (R8)
    for (int i = 0; i < DEPTH - 3; i++) doStore(16'(20 + i), 32'(32'hC000_0000 + i), 4'hF);
    @(negedge clk);
    stValid = 1; stAddr = 16'd40; stData = 32'hDDDD_0040; stBe = 4'hF;
    #3;
    check(!stReady, "R8 full blocks store", 64'(stReady), 64'h0);
    @(negedge clk);
    ackBlock = 0; ackLat = 0;
    #3;
    check(stReady, "R8 accept while head leaves", 64'(stReady), 64'h1);
    @(posedge clk);
    expQ.push_back('{a: 16'd40, d: 32'hDDDD_0040, b: 4'hF});
    applyWord(refImg, '{a: 16'd40, d: 32'hDDDD_0040, b: 4'hF});
    nStores++;
    #1 stValid = 0;

    // drain request (R9)
    ackLat = 2;
    @(negedge clk);
    drainReq = 1;
    #3;
    check(stall == (expQ.size() != 0), "R9 stall on request", 64'(stall), 64'(expQ.size() != 0));
    check(!stReady, "R9 no store while draining", 64'(stReady), 64'h0);
    @(posedge clk);
    #1 drainReq = 0;
    forever begin
      @(negedge clk);
      #3;
      check(stall == (expQ.size() != 0), "R9 stall until empty", 64'(stall), 64'(expQ.size() != 0));
      if (expQ.size() == 0) break;
    end

    // drain on empty (R10)
    @(negedge clk);
    drainReq = 1;
    #3;
    check(!stall, "R10 empty drain", 64'(stall), 64'h0);
    @(posedge clk);
    #1 drainReq = 0;

    // mixed traffic with interleaved loads (R2, R4, R5, R7)
    ackLat = 1;
    for (int i = 0; i < 24; i++) begin
      doStore(16'((i * 7) % 16), 32'(32'h5000_0000 + i * 32'h0101), 4'((i % 3 == 0) ? 4'hF : 4'b1100));
      checkLoad(16'((i * 5) % 16), 4'hF, "R5 mixed load");
    end
    waitEmpty();
    @(negedge clk);

    // final image and write count (R11, R4)
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 64; i++) if (memImg[i] != refImg[i]) bad++;
      check(bad == 0, "R11 memory image", 64'(bad), 64'h0);
    end
    check(nWrites == nStores, "R4 one write per store", 64'(nWrites), 64'(nStores));
    finishRun();
  end
endmodule